// File: doc/BRIEF.md
# Input Capture Pulse Meter

This block times a digital input signal against a free-running timebase. The timebase is built from a prescaler followed by a counter. Software or a neighbouring block picks a prescale value, a capture polarity and a measurement mode, then pulses `start`. The unit catches the timebase on two chosen input edges and reports their wrap-safe difference. In period mode the difference is one full cycle of the input. In pulse-width mode it is the length of the high phase.

Every capture raises an event flag and publishes the counter part of the captured timebase. The flag works as a handshake. The second capture is not armed until the flag has been cleared, so a slow consumer cannot miss the first value. When the second capture lands, a one-cycle valid strobe marks the difference. The unit then stays idle until the next `start`. Turning counts into frequency or duty cycle is left to the consumer.

Top module: `icap_pulse_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cap_count`, `evt_flag`, `diff_out` and `diff_valid` all become zero and the unit goes idle.
- R2: The prescaler counts from 0 up to `cfg_prescale` and then restarts at 0. The counter advances by one each time the prescaler restarts, so the timebase divides the clock by `cfg_prescale`+1. The timebase value is the concatenation {counter, prescaler}, and differences are expressed in that composite unit.
- R3: `sig_in` passes through two synchronising flops before edge detection. A level change sampled at clock edge k is captured at edge k+2, using the timebase value held between edges k+1 and k+2.
- R4: In period mode (`cfg_mode`=0), both captures occur on consecutive edges of the polarity chosen by `cfg_edge` (0 = rising, 1 = falling). `diff_out` is the second capture minus the first.
- R5: In pulse-width mode (`cfg_mode`=1), the first capture occurs on a rising edge and the second on the next falling edge, whatever the value of `cfg_edge`.
- R6: Each capture sets `evt_flag` and loads `cap_count` with the counter part of the captured timebase. A pulse on `evt_clr` clears the flag.
- R7: While `evt_flag` is set, input edges are ignored and `cap_count` holds. The next matching edge after the clear is the one that is captured.
- R8: `diff_valid` is high for exactly one cycle, in the same cycle that `diff_out` takes the new result. The unit then ignores all edges until the next `start`.
- R9: `start` clears `evt_flag` and restarts the sequence from the first capture, even in the middle of a measurement. `cfg_mode` and `cfg_edge` are latched at `start`.
- R10: Differences wrap modulo 2^(PRE_W+CNT_W). A measurement that spans a timebase rollover gives the true elapsed amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | 1 | Asynchronous signal to be measured |
| cfg_prescale | input | PRE_W | Prescaler terminal value (divide by value+1) |
| cfg_edge | input | 1 | Period-mode capture polarity: 0 rising, 1 falling |
| cfg_mode | input | 1 | 0 period, 1 high-pulse width |
| start | input | 1 | Begin (or restart) a measurement |
| evt_clr | input | 1 | Clear the capture event flag |
| cap_count | output | CNT_W | Counter value at the latest capture |
| evt_flag | output | 1 | Capture event status |
| diff_out | output | PRE_W+CNT_W | Wrap-safe difference between the two captures |
| diff_valid | output | 1 | One-cycle strobe marking a new `diff_out` |

## Verification
The bench builds the unit with a 4-bit prescaler and an 8-bit counter. At full prescale the 12-bit timebase then rolls over every 4096 clocks, so a period measurement placed across that boundary fits easily inside the run. A prescale of 3 makes the composite {counter, prescaler} unit visible in the results: the difference grows in steps of 16 per counter increment. Held event flags, restarts that switch the mode mid-measurement, and the three-cycle synchroniser latency are all driven within a few thousand cycles.

// File: rtl/icap_pkg.sv
// Shared types for the input capture pulse meter.
package icap_pkg;
    // Sequencer states: idle, waiting for first capture, waiting for second.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM1 = 2'd1,
        ST_ARM2 = 2'd2
    } icap_state_e;

    // Measurement mode selected at start.
    typedef enum logic {
        MODE_PERIOD = 1'b0,
        MODE_WIDTH  = 1'b1
    } icap_mode_e;
endpackage

// File: rtl/icap_sync_edge.sv
// Synchroniser and edge detector.
// Passes an asynchronous input through STAGES flops, then flags rising and
// falling transitions of the synchronised level for one cycle each.
// Assumes STAGES >= 2 and a single clock domain downstream.
module icap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser chain and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // Compare the synchronised level with its previous value.
    always_comb begin
        rise = chain_q[STAGES-1] & ~prev_q;
        fall = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/icap_timebase.sv
// Prescaled free-running timebase.
// The prescaler counts 0..limit; each restart advances the counter. The output
// timebase is {counter, prescaler}, wrapping at 2^(PRE_W+CNT_W).
// Assumes the limit may change at any time; a prescaler above a lowered
// limit restarts at the next clock.
module icap_timebase #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    localparam int TB_W = PRE_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit,
    output logic [TB_W-1:0]  tb
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the prescaler and carry into the counter at its terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_q >= limit) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tb = {cnt_q, pre_q};

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (pre_q == '0));
endmodule

// File: rtl/icap_capture_seq.sv
// Capture sequencer.
// Arms the first and second captures, selects the wanted edge per mode, gates
// captures on a cleared event flag, and forms the wrap-safe difference.
// Assumes rise/fall are single-cycle pulses from a synchronised source.
module icap_capture_seq
    import icap_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    localparam int TB_W = PRE_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic [TB_W-1:0]  tb,
    input  logic             cfg_edge,
    input  logic             cfg_mode,
    input  logic             start,
    input  logic             evt_clr,
    output logic [CNT_W-1:0] cap_count,
    output logic             evt_flag,
    output logic [TB_W-1:0]  diff_out,
    output logic             diff_valid
);
    icap_state_e      state_q;
    icap_mode_e       mode_q;
    logic             edge_q;
    logic [TB_W-1:0]  first_q;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    logic [TB_W-1:0]  diff_q;
    logic             valid_q;
    logic             want;
    logic             hit;

    // Pick the edge that the current state is waiting for.
    always_comb begin
        unique case (state_q)
            ST_ARM1: want = (mode_q == MODE_WIDTH) ? rise : (edge_q ? fall : rise);
            ST_ARM2: want = (mode_q == MODE_WIDTH) ? fall : (edge_q ? fall : rise);
            default: want = 1'b0;
        endcase
        hit = want & ~flag_q;
    end

    // Sequence the captures, the event flag and the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_PERIOD;
            edge_q  <= 1'b0;
            first_q <= '0;
            cap_q   <= '0;
            flag_q  <= 1'b0;
            diff_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                state_q <= ST_ARM1;
                mode_q  <= icap_mode_e'(cfg_mode);
                edge_q  <= cfg_edge;
                flag_q  <= 1'b0;
            end else if (hit) begin
                flag_q <= 1'b1;
                cap_q  <= tb[TB_W-1 -: CNT_W];
                if (state_q == ST_ARM1) begin
                    first_q <= tb;
                    state_q <= ST_ARM2;
                end else begin
                    diff_q  <= tb - first_q;
                    valid_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
            end else if (evt_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign cap_count  = cap_q;
    assign evt_flag   = flag_q;
    assign diff_out   = diff_q;
    assign diff_valid = valid_q;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6
    valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> flag_q);

    // R7
    held_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !evt_clr && !start) |=> $stable(cap_q));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !valid_q));
endmodule

// File: rtl/icap_pulse_meter.sv
// Input capture pulse meter, top level.
// Synchronises the measured signal, runs the prescaled timebase and
// sequences two captures into a wrap-safe period or pulse-width result.
// Assumes a single clock and a synchronous active-low reset.
module icap_pulse_meter #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int TB_W = PRE_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic             cfg_edge,
    input  logic             cfg_mode,
    input  logic             start,
    input  logic             evt_clr,
    output logic [CNT_W-1:0] cap_count,
    output logic             evt_flag,
    output logic [TB_W-1:0]  diff_out,
    output logic             diff_valid
);
    logic            rise;
    logic            fall;
    logic [TB_W-1:0] tb;

    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise),
        .fall     (fall)
    );

    icap_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (cfg_prescale),
        .tb    (tb)
    );

    icap_capture_seq #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .tb         (tb),
        .cfg_edge   (cfg_edge),
        .cfg_mode   (cfg_mode),
        .start      (start),
        .evt_clr    (evt_clr),
        .cap_count  (cap_count),
        .evt_flag   (evt_flag),
        .diff_out   (diff_out),
        .diff_valid (diff_valid)
    );
endmodule

// File: tb/icap_pulse_meter_tb.sv
`timescale 1ns/1ps
module icap_pulse_meter_tb;
    localparam int PRE_W = 4;
    localparam int CNT_W = 8;
    localparam int TB_W  = PRE_W + CNT_W;
    localparam int TBM   = 1 << TB_W;
    localparam int PREM  = 1 << PRE_W;
    localparam int CNTM  = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic [PRE_W-1:0] cfg_prescale = 4'd15;
    logic             cfg_edge = 1'b0;
    logic             cfg_mode = 1'b0;
    logic             start = 1'b0;
    logic             evt_clr = 1'b0;
    logic [CNT_W-1:0] cap_count;
    logic             evt_flag;
    logic [TB_W-1:0]  diff_out;
    logic             diff_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  auto_clr = 1'b1;
    int  n_valid  = 0;
    int  last_diff = 0;

    // reference model state
    int m_s1, m_s2, m_s3, m_pre, m_cnt, m_state, m_mode, m_edge, m_first;
    int e_cap, e_flag, e_diff, e_valid;

    always #2 clk = ~clk;

    icap_pulse_meter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cfg_prescale(cfg_prescale),
        .cfg_edge(cfg_edge), .cfg_mode(cfg_mode), .start(start), .evt_clr(evt_clr),
        .cap_count(cap_count), .evt_flag(evt_flag), .diff_out(diff_out),
        .diff_valid(diff_valid)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0;
            m_state = 0; m_mode = 0; m_edge = 0; m_first = 0;
            e_cap = 0; e_flag = 0; e_diff = 0; e_valid = 0;
        end else begin
            int rs, fl, tbv, want;
            rs  = (m_s2 == 1 && m_s3 == 0);
            fl  = (m_s2 == 0 && m_s3 == 1);
            tbv = m_cnt * PREM + m_pre;
            want = 0;
            if (m_state == 1) want = m_mode ? rs : (m_edge ? fl : rs);
            if (m_state == 2) want = m_mode ? fl : (m_edge ? fl : rs);
            e_valid = 0;
            if (start) begin
                m_state = 1; e_flag = 0; m_mode = cfg_mode; m_edge = cfg_edge;
            end else if (want && !e_flag) begin
                e_flag = 1; e_cap = m_cnt;
                if (m_state == 1) begin
                    m_first = tbv; m_state = 2;
                end else begin
                    e_diff = (tbv - m_first + TBM) % TBM; e_valid = 1; m_state = 0;
                end
            end else if (evt_clr) begin
                e_flag = 0;
            end
            if (m_pre >= int'(cfg_prescale)) begin
                m_pre = 0; m_cnt = (m_cnt + 1) % CNTM;
            end else begin
                m_pre = m_pre + 1;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
        end
    end

    // Compare the DUT with the model on every clock, away from the edge.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            check("R6 cap_count", int'(cap_count), e_cap);
            check("R6 evt_flag", int'(evt_flag), e_flag);
            check("R4 diff_out", int'(diff_out), e_diff);
            check("R8 diff_valid", int'(diff_valid), e_valid);
            if (diff_valid) begin
                n_valid++;
                last_diff = int'(diff_out);
            end
        end
    end

    // Automatic event-flag clearing, one-cycle pulse per capture.
    initial forever begin
        @(negedge clk);
        if (auto_clr) evt_clr = evt_flag & ~evt_clr;
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wave(input int hi, input int lo, input int n);
        for (int i = 0; i < n; i++) begin
            sig_in = 1'b1;
            repeat (hi) @(negedge clk);
            sig_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v0, c1, c2, lat, capr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cap_count", int'(cap_count), 0);
        check("R1 evt_flag", int'(evt_flag), 0);
        check("R1 diff_out", int'(diff_out), 0);
        check("R1 diff_valid", int'(diff_valid), 0);
        rst_n = 1'b1;

        // R10: period across the timebase rollover (full prescale, tb = cycles)
        repeat (1990) @(negedge clk);
        cfg_mode = 1'b0; cfg_edge = 1'b0;
        pulse_start();
        v0 = n_valid;
        fork
            wave(1000, 2000, 2);
            begin
                @(posedge evt_flag); @(negedge clk); c1 = int'(cap_count);
                @(posedge diff_valid); @(negedge clk); c2 = int'(cap_count);
            end
        join
        repeat (5) @(negedge clk);
        check("R10 wrapped diff", last_diff, 3000);
        check("R10 rollover crossed", int'(c2 < c1), 1);

        // R4: period, rising; R8: later edges ignored
        pulse_start();
        v0 = n_valid;
        fork
            wave(15, 25, 4);
            begin @(posedge diff_valid); @(negedge clk); capr = int'(cap_count); end
        join
        repeat (5) @(negedge clk);
        check("R4 period rising", last_diff, 40);
        check("R8 one result only", n_valid - v0, 1);
        check("R8 idle holds cap_count", int'(cap_count), capr);

        // R4: period, falling polarity
        cfg_edge = 1'b1;
        pulse_start();
        wave(10, 20, 3);
        repeat (5) @(negedge clk);
        check("R4 period falling", last_diff, 30);

        // R5 with cfg_edge ignored; R3 latency from input change to flag
        cfg_mode = 1'b1; cfg_edge = 1'b1;
        pulse_start();
        repeat (3) @(negedge clk);
        sig_in = 1'b1;
        lat = 0;
        while (!evt_flag) begin @(negedge clk); lat++; end
        check("R3 sync latency", lat, 3);
        repeat (13 - lat) @(negedge clk);
        sig_in = 1'b0;
        repeat (27) @(negedge clk);
        wave(13, 27, 1);
        repeat (5) @(negedge clk);
        check("R5 pulse width", last_diff, 13);

        // R2: prescale 3 -> composite unit, 16 per counter step
        cfg_prescale = 4'd3; cfg_edge = 1'b0;
        repeat (20) @(negedge clk);
        pulse_start();
        wave(12, 28, 2);
        repeat (5) @(negedge clk);
        check("R2 width at prescale 3", last_diff, 48);
        cfg_mode = 1'b0;
        pulse_start();
        wave(12, 28, 3);
        repeat (5) @(negedge clk);
        check("R2 period at prescale 3", last_diff, 160);

        // R7: flag held, later edges ignored until cleared
        cfg_prescale = 4'd15;
        repeat (20) @(negedge clk);
        auto_clr = 1'b0;
        pulse_start();
        v0 = n_valid;
        fork
            wave(15, 25, 5);
            begin
                @(posedge evt_flag); @(negedge clk); capr = int'(cap_count);
                repeat (90) @(negedge clk);
                check("R7 cap_count held", int'(cap_count), capr);
                check("R7 no result while held", n_valid - v0, 0);
                evt_clr = 1'b1;
                @(negedge clk);
                evt_clr = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        check("R7 capture after clear", last_diff, 120);
        auto_clr = 1'b1;

        // R9: restart mid-measurement, switching to pulse-width mode
        cfg_mode = 1'b0;
        pulse_start();
        v0 = n_valid;
        fork
            wave(15, 25, 4);
            begin
                @(posedge evt_flag);
                repeat (20) @(negedge clk);
                cfg_mode = 1'b1;
                pulse_start();
                check("R9 flag cleared by start", int'(evt_flag), 0);
                cfg_mode = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        check("R9 restarted in width mode", last_diff, 15);
        check("R9 single result", n_valid - v0, 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule